// File: doc/BRIEF.md
# Dual-Line Serial Read Engine

This block is the data path behind the two fast read modes of a serial NOR flash slave that return data on two lines at once. After the command byte has been decoded elsewhere, a one-cycle start pulse hands over the opcode. The engine then counts the address and dummy phases on the serial clock strobes and collects the address. It fetches bytes from the array through a simple address/data port. It streams each byte out as four bit pairs on the two data lines and advances the address after every byte.

The two modes differ in how the host talks to the engine before data flows. In the single-lane-address mode (opcode 3Bh), the address arrives one bit per clock on line 0 and is followed by a longer dummy phase. In the dual-lane-address mode (opcode BBh), the address arrives two bits per clock and is followed by a shorter dummy phase that carries a repeated bit pair. Both output enables stay low until the first data cycle, so the host keeps ownership of line 0 through the address and dummy phases. Everything runs on one fast system clock; the serial clock edges come in as one-cycle strobes.

Top module: `dualread_engine`

## Requirements
- R1: Opcode 3Bh captures ADDR_BITS address bits on `si0In`, one per `sclkRise`, most significant bit first. Only the low log2(ARRAY_BYTES) bits select the first byte read.
- R2: In the 3Bh mode, SINGLE_DUMMY rising strobes follow the address. Both enables stay 0 from the start through the last dummy rise, and rise on the next `sclkFall` together with the first data pair.
- R3: Opcode BBh captures the address as ADDR_BITS/2 pairs on rising strobes, most significant pair first. `si1In` carries the odd bit and `si0In` the even bit of each pair.
- R4: In the BBh mode, DUAL_DUMMY rising strobes follow the address, and the first data pair appears on the `sclkFall` after the last of them.
- R5: In the BBh mode, the pair sampled on the second dummy rise must equal the pair sampled on the first (`si1In` against `si1In`, `si0In` against `si0In`). On a mismatch no output is enabled until `csN` rises.
- R6: Each byte leaves on four consecutive `sclkFall` strobes. `sio1Out` carries bits 7,5,3,1 and `sio0Out` carries bits 6,4,2,0, in that order. The outputs change only on a cycle following a `sclkFall`.
- R7: Bytes follow one another with no gap, from consecutive ascending addresses.
- R8: After the byte at address ARRAY_BYTES-1 comes the byte at address 0.
- R9: A high `csN` drops both enables on the next clock and returns the engine to idle, and a new start after `csN` falls again is served normally.
- R10: A start while `writeBusy` is high is refused, and no enable rises until `csN` goes high.
- R11: A start with any opcode other than 3Bh or BBh is refused in the same way.
- R12: During and right after reset both enables and both data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low, synchronised |
| sclkRise | input | 1 | One-cycle strobe marking a rising serial clock edge |
| sclkFall | input | 1 | One-cycle strobe marking a falling serial clock edge |
| start | input | 1 | One-cycle pulse: a read command byte has been decoded |
| opcode | input | 8 | Command code that goes with `start` |
| writeBusy | input | 1 | A program, erase or status write is in progress |
| si0In | input | 1 | Sampled level of data line 0 |
| si1In | input | 1 | Sampled level of data line 1 |
| fetchAddr | output | log2(ARRAY_BYTES) | Byte address presented to the array |
| fetchData | input | 8 | Array byte at `fetchAddr`, combinational |
| sio0Out | output | 1 | Data driven onto line 0 |
| sio0Oe | output | 1 | Output enable for line 0 |
| sio1Out | output | 1 | Data driven onto line 1 |
| sio1Oe | output | 1 | Output enable for line 1 |

## Verification
The bench builds the engine with ARRAY_BYTES set to 256 and keeps the 24-bit address and the 8 and 4 dummy counts. With the smaller array, the wrap from the last address to zero takes a short read started near the top. Upper address bits that the array cannot decode can then be set to nonzero values and shown to have no effect. The full dummy counts keep the exact cycle of the line-0 turnaround under test in both modes.

// File: rtl/dualread_pkg.sv
package dualread_pkg;

  localparam logic [7:0] OPC_ONE_LANE_ADDR = 8'h3B;
  localparam logic [7:0] OPC_TWO_LANE_ADDR = 8'hBB;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_HALT
  } rdState_t;

  typedef struct packed {
    logic       shiftOne;
    logic       shiftTwo;
    logic       saveMode;
    logic       loadFirst;
    logic       drive;
    logic       prefetch;
    logic       clear;
    logic [1:0] pairIdx;
  } dpStrobe_t;

endpackage

// File: rtl/dualread_dp.sv
module dualread_dp
  import dualread_pkg::*;
#(
  parameter int ARRAY_BYTES = 131072,
  parameter int ARR_W       = $clog2(ARRAY_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        ctl,
  input  logic             si0In,
  input  logic             si1In,
  input  logic [7:0]       fetchData,
  output logic [ARR_W-1:0] fetchAddr,
  output logic             pairEq,
  output logic             sio0Out,
  output logic             sio0Oe,
  output logic             sio1Out,
  output logic             sio1Oe
);

  localparam logic [ARR_W-1:0] LAST_ADDR = ARR_W'(ARRAY_BYTES - 1);

  logic [ARR_W-1:0] addrReg;
  logic [ARR_W-1:0] nextAddr;
  logic [7:0]       curByte;
  logic [1:0]       savedPair;
  logic             pickHi;
  logic             pickLo;

  assign fetchAddr = addrReg;
  assign nextAddr  = (addrReg == LAST_ADDR) ? '0 : addrReg + 1'b1;
  assign pairEq    = ({si1In, si0In} == savedPair);

  // odd bit to line 1, even bit to line 0, high pair first
  always_comb begin
    unique case (ctl.pairIdx)
      2'd0:    begin pickHi = curByte[7]; pickLo = curByte[6]; end
      2'd1:    begin pickHi = curByte[5]; pickLo = curByte[4]; end
      2'd2:    begin pickHi = curByte[3]; pickLo = curByte[2]; end
      default: begin pickHi = curByte[1]; pickLo = curByte[0]; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg   <= '0;
      curByte   <= '0;
      savedPair <= '0;
      sio0Out   <= 1'b0;
      sio1Out   <= 1'b0;
      sio0Oe    <= 1'b0;
      sio1Oe    <= 1'b0;
    end else if (ctl.clear) begin
      sio0Out <= 1'b0;
      sio1Out <= 1'b0;
      sio0Oe  <= 1'b0;
      sio1Oe  <= 1'b0;
    end else begin
      if (ctl.shiftOne) begin
        addrReg <= {addrReg[ARR_W-2:0], si0In};
      end else if (ctl.shiftTwo) begin
        addrReg <= {addrReg[ARR_W-3:0], si1In, si0In};
      end else if (ctl.loadFirst || ctl.prefetch) begin
        addrReg <= nextAddr;
      end
      if (ctl.loadFirst || ctl.prefetch) begin
        curByte <= fetchData;
      end
      if (ctl.saveMode) begin
        savedPair <= {si1In, si0In};
      end
      if (ctl.drive) begin
        sio1Out <= pickHi;
        sio0Out <= pickLo;
        sio1Oe  <= 1'b1;
        sio0Oe  <= 1'b1;
      end
    end
  end

  // R8
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.clear && ctl.prefetch && addrReg == LAST_ADDR) |=> (addrReg == '0));

endmodule

// File: rtl/dualread_ctrl.sv
module dualread_ctrl
  import dualread_pkg::*;
#(
  parameter int ADDR_BITS    = 24,
  parameter int SINGLE_DUMMY = 8,
  parameter int DUAL_DUMMY   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclkRise,
  input  logic       sclkFall,
  input  logic       start,
  input  logic [7:0] opcode,
  input  logic       writeBusy,
  input  logic       pairEq,
  output dpStrobe_t  ctl
);

  localparam int MAX_A  = (ADDR_BITS > SINGLE_DUMMY) ? ADDR_BITS : SINGLE_DUMMY;
  localparam int MAX_C  = (MAX_A > DUAL_DUMMY) ? MAX_A : DUAL_DUMMY;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] ADDR_LAST_ONE  = CNT_W'(ADDR_BITS - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST_TWO  = CNT_W'(ADDR_BITS / 2 - 1);
  localparam logic [CNT_W-1:0] DUMMY_LAST_ONE = CNT_W'(SINGLE_DUMMY - 1);
  localparam logic [CNT_W-1:0] DUMMY_LAST_TWO = CNT_W'(DUAL_DUMMY - 1);

  rdState_t         state, nState;
  logic [CNT_W-1:0] cnt, nCnt;
  logic             dual, nDual;
  logic [1:0]       pairIdx, nPair;
  logic [CNT_W-1:0] addrLast;
  logic [CNT_W-1:0] dummyLast;
  logic             opcodeOk;

  assign addrLast  = dual ? ADDR_LAST_TWO : ADDR_LAST_ONE;
  assign dummyLast = dual ? DUMMY_LAST_TWO : DUMMY_LAST_ONE;
  assign opcodeOk  = (opcode == OPC_ONE_LANE_ADDR) || (opcode == OPC_TWO_LANE_ADDR);

  always_comb begin
    ctl    = '0;
    nState = state;
    nCnt   = cnt;
    nDual  = dual;
    nPair  = pairIdx;
    if (csN) begin
      ctl.clear = 1'b1;
      nState    = ST_IDLE;
      nCnt      = '0;
      nPair     = '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (writeBusy || !opcodeOk) begin
              nState = ST_HALT;
            end else begin
              nState = ST_ADDR;
              nDual  = (opcode == OPC_TWO_LANE_ADDR);
              nCnt   = '0;
            end
          end
        end
        ST_ADDR: begin
          if (sclkRise) begin
            ctl.shiftTwo = dual;
            ctl.shiftOne = !dual;
            if (cnt == addrLast) begin
              nState = ST_DUMMY;
              nCnt   = '0;
            end else begin
              nCnt = cnt + 1'b1;
            end
          end
        end
        ST_DUMMY: begin
          if (sclkRise) begin
            if (dual && cnt == '0) begin
              ctl.saveMode = 1'b1;
            end
            if (dual && cnt == CNT_W'(1) && !pairEq) begin
              nState = ST_HALT;
            end else if (cnt == dummyLast) begin
              nState        = ST_DATA;
              ctl.loadFirst = 1'b1;
              nPair         = '0;
            end else begin
              nCnt = cnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (sclkFall) begin
            ctl.drive    = 1'b1;
            ctl.pairIdx  = pairIdx;
            ctl.prefetch = (pairIdx == 2'd3);
            nPair        = pairIdx + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      dual    <= 1'b0;
      pairIdx <= '0;
    end else begin
      state   <= nState;
      cnt     <= nCnt;
      dual    <= nDual;
      pairIdx <= nPair;
    end
  end

  // R10
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && $past(state) == ST_IDLE) |-> !$past(writeBusy));

  // R11
  opcode_filter_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && $past(state) == ST_IDLE) |->
      ($past(opcode) == OPC_ONE_LANE_ADDR || $past(opcode) == OPC_TWO_LANE_ADDR));

endmodule

// File: rtl/dualread_engine.sv
module dualread_engine
  import dualread_pkg::*;
#(
  parameter int ADDR_BITS    = 24,
  parameter int SINGLE_DUMMY = 8,
  parameter int DUAL_DUMMY   = 4,
  parameter int ARRAY_BYTES  = 131072,
  parameter int ARR_W        = $clog2(ARRAY_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sclkRise,
  input  logic             sclkFall,
  input  logic             start,
  input  logic [7:0]       opcode,
  input  logic             writeBusy,
  input  logic             si0In,
  input  logic             si1In,
  output logic [ARR_W-1:0] fetchAddr,
  input  logic [7:0]       fetchData,
  output logic             sio0Out,
  output logic             sio0Oe,
  output logic             sio1Out,
  output logic             sio1Oe
);

  dpStrobe_t ctl;
  logic      pairEq;

  dualread_ctrl #(
    .ADDR_BITS   (ADDR_BITS),
    .SINGLE_DUMMY(SINGLE_DUMMY),
    .DUAL_DUMMY  (DUAL_DUMMY)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .sclkRise (sclkRise),
    .sclkFall (sclkFall),
    .start    (start),
    .opcode   (opcode),
    .writeBusy(writeBusy),
    .pairEq   (pairEq),
    .ctl      (ctl)
  );

  dualread_dp #(
    .ARRAY_BYTES(ARRAY_BYTES),
    .ARR_W      (ARR_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .si0In    (si0In),
    .si1In    (si1In),
    .fetchData(fetchData),
    .fetchAddr(fetchAddr),
    .pairEq   (pairEq),
    .sio0Out  (sio0Out),
    .sio0Oe   (sio0Oe),
    .sio1Out  (sio1Out),
    .sio1Oe   (sio1Oe)
  );

  // R9
  cs_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (!sio0Oe && !sio1Oe));

  // R6
  change_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sclkFall && !csN) |=> ($stable(sio0Out) && $stable(sio1Out)));

  // R2
  enable_at_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sio1Oe) |-> $past(sclkFall));

endmodule

// File: tb/dualread_engine_test.sv
module dualread_engine_test;

  localparam int ARRAY_BYTES = 256;
  localparam int ARR_W       = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             csN = 1'b1;
  logic             sclkRise = 1'b0;
  logic             sclkFall = 1'b0;
  logic             start = 1'b0;
  logic [7:0]       opcode = 8'h00;
  logic             writeBusy = 1'b0;
  logic             si0In = 1'b0;
  logic             si1In = 1'b0;
  logic [ARR_W-1:0] fetchAddr;
  logic [7:0]       fetchData;
  logic             sio0Out, sio0Oe, sio1Out, sio1Oe;

  int  vectors = 0;
  int  miscompares = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [7:0] memAt(logic [ARR_W-1:0] a);
    return (a * 8'd29) ^ 8'hA5;
  endfunction

  assign fetchData = memAt(fetchAddr);

  dualread_engine #(.ARRAY_BYTES(ARRAY_BYTES)) uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .start(start), .opcode(opcode), .writeBusy(writeBusy), .si0In(si0In), .si1In(si1In),
    .fetchAddr(fetchAddr), .fetchData(fetchData),
    .sio0Out(sio0Out), .sio0Oe(sio0Oe), .sio1Out(sio1Out), .sio1Oe(sio1Oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one serial clock: rise with pins driven, then fall; samples after the fall
  task automatic bitCycle(input logic b1, input logic b0, output logic oeBefore,
                          output logic o1, output logic o0, output logic e1, output logic e0);
    @(negedge clk); si1In = b1; si0In = b0; sclkRise = 1'b1;
    @(negedge clk); sclkRise = 1'b0;
    @(negedge clk); oeBefore = sio0Oe | sio1Oe; sclkFall = 1'b1;
    @(negedge clk); sclkFall = 1'b0;
    o1 = sio1Out; o0 = sio0Out; e1 = sio1Oe; e0 = sio0Oe;
  endtask

  task automatic beginRead(input logic [7:0] op);
    @(negedge clk); csN = 1'b0;
    @(negedge clk); start = 1'b1; opcode = op;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic endRead(input string req);
    @(negedge clk); csN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(req, {6'd0, sio1Oe, sio0Oe}, 8'h00);
  endtask

  task automatic quietCycle(input logic b1, input logic b0, input string req);
    logic ob, o1, o0, e1, e0;
    bitCycle(b1, b0, ob, o1, o0, e1, e0);
    chk(req, {6'd0, e1, e0}, 8'h00);
  endtask

  task automatic sendAddrOne(input logic [23:0] a, input string req);
    for (int i = 23; i >= 0; i--) quietCycle(1'b0, a[i], req);
  endtask

  task automatic sendAddrTwo(input logic [23:0] a, input string req);
    for (int i = 23; i >= 1; i -= 2) quietCycle(a[i], a[i-1], req);
  endtask

  // first pair's rise is the last dummy rise
  task automatic takeBytes(input logic [ARR_W-1:0] a, input int n, input string req);
    logic ob, o1, o0, e1, e0;
    logic [7:0] got;
    logic [ARR_W-1:0] cur;
    cur = a;
    for (int b = 0; b < n; b++) begin
      got = '0;
      for (int k = 0; k < 4; k++) begin
        bitCycle(1'b0, 1'b0, ob, o1, o0, e1, e0);
        if (b == 0 && k == 0) chk({req, " R2 enable low before first fall"}, {7'd0, ob}, 8'h00);
        chk({req, " R6 enables during data"}, {6'd0, e1, e0}, 8'h03);
        got[7 - 2*k] = o1;
        got[6 - 2*k] = o0;
      end
      chk({req, " R7 byte"}, got, memAt(cur));
      cur = cur + 1'b1;
    end
  endtask

  task automatic testReset();
    chk("R12 reset enables", {6'd0, sio1Oe, sio0Oe}, 8'h00);
    chk("R12 reset data", {6'd0, sio1Out, sio0Out}, 8'h00);
  endtask

  task automatic testSingleLane();
    beginRead(8'h3B);
    sendAddrOne(24'h3A0010, "R1 address phase enables");
    for (int d = 0; d < 7; d++) quietCycle(1'b1, 1'b1, "R2 dummy enables");
    takeBytes(8'h10, 3, "R1");
    endRead("R9 end of single lane read");
  endtask

  task automatic testDualLane();
    beginRead(8'hBB);
    sendAddrTwo(24'h0000A7, "R3 address phase enables");
    quietCycle(1'b1, 1'b0, "R4 dummy0");
    quietCycle(1'b1, 1'b0, "R4 dummy1");
    quietCycle(1'b0, 1'b1, "R4 dummy2");
    takeBytes(8'hA7, 3, "R3 R4");
    endRead("R9 end of dual lane read");
  endtask

  task automatic testMismatch();
    beginRead(8'hBB);
    sendAddrTwo(24'h000033, "R5 address phase");
    quietCycle(1'b1, 1'b0, "R5 dummy0");
    quietCycle(1'b0, 1'b1, "R5 dummy1 mismatch");
    for (int i = 0; i < 10; i++) quietCycle(1'b0, 1'b0, "R5 no output after mismatch");
    endRead("R9 after mismatch");
  endtask

  task automatic testWrap();
    beginRead(8'h3B);
    sendAddrOne(24'h0000FE, "R8 address phase");
    for (int d = 0; d < 7; d++) quietCycle(1'b0, 1'b0, "R8 dummy");
    takeBytes(8'hFE, 4, "R8 wrap");
    endRead("R9 after wrap");
  endtask

  task automatic testBusy();
    writeBusy = 1'b1;
    beginRead(8'h3B);
    writeBusy = 1'b0;
    sendAddrOne(24'h000020, "R10 busy address");
    for (int i = 0; i < 16; i++) quietCycle(1'b0, 1'b0, "R10 busy refused");
    endRead("R10 busy end");
  endtask

  task automatic testBadOpcode();
    beginRead(8'h03);
    sendAddrOne(24'h000020, "R11 bad opcode address");
    for (int i = 0; i < 16; i++) quietCycle(1'b0, 1'b0, "R11 bad opcode refused");
    endRead("R11 bad opcode end");
  endtask

  task automatic testCsAbort();
    logic ob, o1, o0, e1, e0;
    beginRead(8'h3B);
    sendAddrOne(24'h000040, "R9 abort address");
    for (int d = 0; d < 7; d++) quietCycle(1'b0, 1'b0, "R9 abort dummy");
    bitCycle(1'b0, 1'b0, ob, o1, o0, e1, e0);
    chk("R9 first pair enabled", {6'd0, e1, e0}, 8'h03);
    bitCycle(1'b0, 1'b0, ob, o1, o0, e1, e0);
    endRead("R9 cs rise mid byte");
    beginRead(8'hBB);
    sendAddrTwo(24'h000080, "R9 restart address");
    quietCycle(1'b0, 1'b1, "R9 restart dummy0");
    quietCycle(1'b0, 1'b1, "R9 restart dummy1");
    quietCycle(1'b0, 1'b0, "R9 restart dummy2");
    takeBytes(8'h80, 2, "R9 restart");
    endRead("R9 restart end");
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSingleLane();
    testDualLane();
    testMismatch();
    testWrap();
    testBusy();
    testBadOpcode();
    testCsAbort();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end

endmodule